// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit owns the program counter of a word-aligned 32-bit machine and decides, for the instruction currently presented, where execution continues. From the current PC, the 6-bit opcode, the value read from the Ra register and the 16-bit literal, it produces the next PC, the link value to be written into Rc together with its write enable, and the effective address of a PC-relative load. The register file and memory sit outside the unit.

The held PC moves to the computed next PC on each instruction-complete strobe and holds otherwise. Only a 20-bit word index is stored, so the byte PC spans 4 MiB: bits 1:0 and bits 31:22 always read as zero and all address arithmetic wraps within that span. The branch decision uses the Ra value present at the strobe edge, so a link write into the same register at that edge cannot alter the outcome.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, whatever the other inputs do.
- R2: For any opcode other than 0x1B, 0x1D, 0x1E and 0x1F, `next_pc_o` is `pc_o`+4, `link_we_o` is 0, and a strobe moves `pc_o` to that value.
- R3: Opcode 0x1B (jump) gives `next_pc_o` = `ra_val_i` with bits 1:0 cleared, `link_we_o` = 1 and `link_o` = `pc_o`+4.
- R4: Opcode 0x1D (branch if zero) gives `link_we_o` = 1 and `link_o` = `pc_o`+4 in every case; `next_pc_o` is `pc_o`+4+4×sign-extended literal when `ra_val_i` is 0, otherwise `pc_o`+4.
- R5: Opcode 0x1E (branch if nonzero) behaves like 0x1D but takes the relative target when `ra_val_i` is nonzero.
- R6: The branch outcome is fixed by `ra_val_i` at the strobe edge; a change of `ra_val_i` afterwards (the link write landing in Ra) leaves `pc_o` unchanged.
- R7: Opcode 0x1F (PC-relative load) gives `ldr_addr_o` = `pc_o`+4+4×sign-extended literal, `link_we_o` = 0 and `next_pc_o` = `pc_o`+4.
- R8: All addresses out of the unit are reduced modulo 2^22 with bits 1:0 at zero; a jump to 0xFFFFFFFF lands on 0x003FFFFC and the next sequential step lands on 0.
- R9: Without a strobe `pc_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction-complete strobe; loads the next PC |
| op_i | input | 6 | Opcode of the current instruction |
| ra_val_i | input | 32 | Value read from register Ra |
| lit_i | input | 16 | Literal field, two's complement |
| pc_o | output | 32 | Current PC |
| next_pc_o | output | 32 | PC that the next strobe will load |
| link_o | output | 32 | Value to write into Rc (current PC+4) |
| link_we_o | output | 1 | Write enable for Rc |
| ldr_addr_o | output | 32 | Effective address of a PC-relative load |

## Verification
The hardest situation to reach is the one where Ra and Rc name the same register: the link write and the branch decision meet at one edge, and a wrong design would branch on the freshly written link value. The bench issues a taken branch on Ra = 0 and, right after the edge, replaces the Ra value with the link value as a register file would, then confirms that the PC stays on the taken target. The wrap of the 22-bit address span is reached by a jump to an all-ones register value followed by a sequential step.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h1B;
  localparam logic [OPC_W-1:0] OPC_BRZ   = 6'h1D;
  localparam logic [OPC_W-1:0] OPC_BRNZ  = 6'h1E;
  localparam logic [OPC_W-1:0] OPC_LDREL = 6'h1F;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_JUMP,
    FLOW_BRZ,
    FLOW_BRNZ,
    FLOW_LDREL
  } flow_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  output flow_e            flow_o,
  output logic             link_we_o
);

  always_comb begin
    flow_o    = FLOW_SEQ;
    link_we_o = 1'b0;
    unique case (op_i)
      OPC_JUMP: begin
        flow_o    = FLOW_JUMP;
        link_we_o = 1'b1;
      end
      OPC_BRZ: begin
        flow_o    = FLOW_BRZ;
        link_we_o = 1'b1;
      end
      OPC_BRNZ: begin
        flow_o    = FLOW_BRNZ;
        link_we_o = 1'b1;
      end
      OPC_LDREL: begin
        flow_o    = FLOW_LDREL;
        link_we_o = 1'b0;
      end
      default: begin
        flow_o    = FLOW_SEQ;
        link_we_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/npc_addr_calc.sv
module npc_addr_calc #(
  parameter int WORD_BITS = 20,
  parameter int LIT_W     = 16
) (
  input  logic [WORD_BITS-1:0] cur_word_i,
  input  logic [LIT_W-1:0]     lit_i,
  input  logic [WORD_BITS-1:0] ra_word_i,
  output logic [WORD_BITS-1:0] inc_word_o,
  output logic [WORD_BITS-1:0] rel_word_o,
  output logic [WORD_BITS-1:0] jmp_word_o
);

  logic [WORD_BITS-1:0] lit_words;

  generate
    if (LIT_W < WORD_BITS) begin : g_lit_sext
      assign lit_words = {{(WORD_BITS-LIT_W){lit_i[LIT_W-1]}}, lit_i};
    end else begin : g_lit_trunc
      assign lit_words = lit_i[WORD_BITS-1:0];
    end
  endgenerate

  // Word-index arithmetic: +1 word is +4 bytes, the literal counts words.
  always_comb begin
    inc_word_o = cur_word_i + WORD_BITS'(1);
    rel_word_o = inc_word_o + lit_words;
    jmp_word_o = ra_word_i;
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int WORD_BITS = 20
) (
  input  flow_e                flow_i,
  input  logic                 ra_zero_i,
  input  logic [WORD_BITS-1:0] inc_word_i,
  input  logic [WORD_BITS-1:0] rel_word_i,
  input  logic [WORD_BITS-1:0] jmp_word_i,
  output logic [WORD_BITS-1:0] next_word_o
);

  always_comb begin
    next_word_o = inc_word_i;
    unique case (flow_i)
      FLOW_JUMP: next_word_o = jmp_word_i;
      FLOW_BRZ:  if (ra_zero_i)  next_word_o = rel_word_i;
      FLOW_BRNZ: if (!ra_zero_i) next_word_o = rel_word_i;
      default:   next_word_o = inc_word_i;
    endcase
  end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int WORD_BITS = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en_i,
  input  logic [WORD_BITS-1:0] next_word_i,
  output logic [WORD_BITS-1:0] word_o
);

  logic [WORD_BITS-1:0] word_d;
  logic [WORD_BITS-1:0] word_q;

  always_comb begin
    word_d = word_q;
    if (load_en_i) word_d = next_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int WORD_BITS = 20,
  parameter int LIT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [OPC_W-1:0] op_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [LIT_W-1:0] lit_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  link_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  ldr_addr_o
);

  localparam int SPAN_BITS = WORD_BITS + 2;
  localparam int PAD_BITS  = XLEN - SPAN_BITS;

  flow_e                flow;
  logic                 ra_zero;
  logic [WORD_BITS-1:0] cur_word;
  logic [WORD_BITS-1:0] inc_word;
  logic [WORD_BITS-1:0] rel_word;
  logic [WORD_BITS-1:0] jmp_word;
  logic [WORD_BITS-1:0] next_word;

  // Decision taken from Ra as seen at the strobe edge.
  assign ra_zero = (ra_val_i == '0);

  npc_decode u_decode (
    .op_i      (op_i),
    .flow_o    (flow),
    .link_we_o (link_we_o)
  );

  npc_addr_calc #(
    .WORD_BITS (WORD_BITS),
    .LIT_W     (LIT_W)
  ) u_addr_calc (
    .cur_word_i (cur_word),
    .lit_i      (lit_i),
    .ra_word_i  (ra_val_i[SPAN_BITS-1:2]),
    .inc_word_o (inc_word),
    .rel_word_o (rel_word),
    .jmp_word_o (jmp_word)
  );

  npc_select #(
    .WORD_BITS (WORD_BITS)
  ) u_select (
    .flow_i      (flow),
    .ra_zero_i   (ra_zero),
    .inc_word_i  (inc_word),
    .rel_word_i  (rel_word),
    .jmp_word_i  (jmp_word),
    .next_word_o (next_word)
  );

  npc_pc_reg #(
    .WORD_BITS (WORD_BITS)
  ) u_pc_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en_i   (step_i),
    .next_word_i (next_word),
    .word_o      (cur_word)
  );

  generate
    if (PAD_BITS > 0) begin : g_pad
      assign pc_o       = {{PAD_BITS{1'b0}}, cur_word,  2'b00};
      assign next_pc_o  = {{PAD_BITS{1'b0}}, next_word, 2'b00};
      assign link_o     = {{PAD_BITS{1'b0}}, inc_word,  2'b00};
      assign ldr_addr_o = {{PAD_BITS{1'b0}}, rel_word,  2'b00};
    end else begin : g_full
      assign pc_o       = {cur_word,  2'b00};
      assign next_pc_o  = {next_word, 2'b00};
      assign link_o     = {inc_word,  2'b00};
      assign ldr_addr_o = {rel_word,  2'b00};
    end
  endgenerate

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int WORD_BITS = 20,
  parameter int LIT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_i,
  input logic [OPC_W-1:0] op_i,
  input logic [XLEN-1:0]  ra_val_i,
  input logic [LIT_W-1:0] lit_i,
  input logic [XLEN-1:0]  pc_o,
  input logic [XLEN-1:0]  next_pc_o,
  input logic [XLEN-1:0]  link_o,
  input logic             link_we_o,
  input logic [XLEN-1:0]  ldr_addr_o
);

  localparam logic [XLEN-1:0] SPAN_MASK = XLEN'((64'd1 << (WORD_BITS + 2)) - 64'd1);

  logic            is_ctl;
  logic            is_other;
  logic [XLEN-1:0] lit_bytes;
  logic [XLEN-1:0] pc_plus4;

  assign is_ctl    = (op_i == OPC_JUMP) || (op_i == OPC_BRZ) || (op_i == OPC_BRNZ);
  assign is_other  = !is_ctl && (op_i != OPC_LDREL);
  assign lit_bytes = {{(XLEN-LIT_W){lit_i[LIT_W-1]}}, lit_i} << 2;
  assign pc_plus4  = (pc_o + XLEN'(4)) & SPAN_MASK;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (pc_o == '0);
    end
  end

  a_r8_span_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ((pc_o & ~SPAN_MASK) == '0) && (pc_o[1:0] == 2'b00));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(pc_o));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && is_other) |=> (pc_o == (($past(pc_o) + XLEN'(4)) & SPAN_MASK)));

  a_r2_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (is_other || op_i == OPC_LDREL) |-> !link_we_o);

  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OPC_JUMP) |=> (pc_o == ($past(ra_val_i) & SPAN_MASK & ~XLEN'(3))));

  a_r4_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctl |-> (link_we_o && link_o == pc_plus4));

  a_r4_brz_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OPC_BRZ && ra_val_i != '0) |=>
      (pc_o == (($past(pc_o) + XLEN'(4)) & SPAN_MASK)));

  a_r5_brnz_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && op_i == OPC_BRNZ && ra_val_i == '0) |=>
      (pc_o == (($past(pc_o) + XLEN'(4)) & SPAN_MASK)));

  a_r7_ldr_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OPC_LDREL) |-> (ldr_addr_o == ((pc_plus4 + lit_bytes) & SPAN_MASK)
                             && next_pc_o == pc_plus4));

endmodule

bind npc_unit npc_unit_chk #(
  .XLEN      (XLEN),
  .WORD_BITS (WORD_BITS),
  .LIT_W     (LIT_W)
) u_npc_unit_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .op_i       (op_i),
  .ra_val_i   (ra_val_i),
  .lit_i      (lit_i),
  .pc_o       (pc_o),
  .next_pc_o  (next_pc_o),
  .link_o     (link_o),
  .link_we_o  (link_we_o),
  .ldr_addr_o (ldr_addr_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SPAN = 32'h003F_FFFF;

  logic        clk;
  logic        rst_n;
  logic        step_i;
  logic [5:0]  op_i;
  logic [31:0] ra_val_i;
  logic [15:0] lit_i;
  logic [31:0] pc_o;
  logic [31:0] next_pc_o;
  logic [31:0] link_o;
  logic        link_we_o;
  logic [31:0] ldr_addr_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] mdl_pc;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  npc_unit u_npc_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .op_i       (op_i),
    .ra_val_i   (ra_val_i),
    .lit_i      (lit_i),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .link_o     (link_o),
    .link_we_o  (link_we_o),
    .ldr_addr_o (ldr_addr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] wrap(input logic [31:0] v);
    return v & SPAN & ~32'd3;
  endfunction

  function automatic logic [31:0] sext4(input logic [15:0] l);
    return {{16{l[15]}}, l} << 2;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one instruction with a strobe, checks the
  // combinational outputs, and queues the PC expected after the edge.
  task automatic issue(input logic [5:0] op, input logic [31:0] ra,
                       input logic [15:0] lit, input string tag);
    logic [31:0] inc;
    logic [31:0] rel;
    logic [31:0] nxt;
    logic        we;
    @(negedge clk);
    op_i = op; ra_val_i = ra; lit_i = lit; step_i = 1'b1;
    inc = wrap(mdl_pc + 32'd4);
    rel = wrap(mdl_pc + 32'd4 + sext4(lit));
    case (op)
      6'h1B:   begin nxt = wrap(ra);                    we = 1'b1; end
      6'h1D:   begin nxt = (ra == 32'd0) ? rel : inc;   we = 1'b1; end
      6'h1E:   begin nxt = (ra != 32'd0) ? rel : inc;   we = 1'b1; end
      default: begin nxt = inc;                         we = 1'b0; end
    endcase
    #1;
    check(tag, "next_pc", next_pc_o, nxt);
    check(tag, "link_we", {31'd0, link_we_o}, {31'd0, we});
    if (we) check(tag, "link", link_o, inc);
    if (op == 6'h1F) check(tag, "ldr_addr", ldr_addr_o, rel);
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
    mdl_pc = nxt;
    @(posedge clk);
    #2 step_i = 1'b0;
  endtask

  // Monitor: pops the expected PC for every strobe edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && step_i && exp_q.size() > 0) begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        #1 check(t, "pc", pc_o, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_i = 1'b1; op_i = 6'h20; ra_val_i = 32'hFFFF_FFFF; lit_i = 16'h7FFF;
    mdl_pc = 32'd0;
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", pc_o, 32'd0);
    step_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pc after reset", pc_o, 32'd0);

    issue(6'h20, 32'd0, 16'd0, "R2");            // plain op -> 4
    issue(6'h2A, 32'd7, 16'h8000, "R2");         // another plain op -> 8
    issue(6'h1B, 32'h1234_5677, 16'd0, "R3");    // jump -> 0x345674
    issue(6'h1D, 32'd0, 16'hFFFE, "R4");         // taken, backward
    issue(6'h1D, 32'd5, 16'h0010, "R4");         // not taken
    issue(6'h1E, 32'h8000_0000, 16'd3, "R5");    // taken forward
    issue(6'h1E, 32'd0, 16'h0040, "R5");         // not taken
    issue(6'h1F, 32'd9, 16'h0100, "R7");         // relative load address
    issue(6'h1F, 32'd9, 16'hFF00, "R7");         // negative literal

    // R8: jump to all-ones, then wrap to zero on the next step
    issue(6'h1B, 32'hFFFF_FFFF, 16'd0, "R8");
    issue(6'h21, 32'd0, 16'd0, "R8");
    issue(6'h1D, 32'd0, 16'hFFFF, "R8");         // rel target 4-4 = 0

    // R6: Ra and Rc are the same register; link value lands after the edge
    issue(6'h1B, 32'h0000_1000, 16'd0, "R6");
    issue(6'h1D, 32'd0, 16'h0020, "R6");
    ra_val_i = link_o;                           // register file write-back
    @(negedge clk);
    check("R6", "pc after link write", pc_o, mdl_pc);
    @(negedge clk);
    check("R6", "pc still on target", pc_o, mdl_pc);

    // R9: no strobe, inputs moving
    op_i = 6'h1B; ra_val_i = 32'h0000_2220; step_i = 1'b0;
    @(negedge clk);
    ra_val_i = 32'h0000_0000; op_i = 6'h1D;
    @(negedge clk);
    op_i = 6'h20;
    @(negedge clk);
    check("R9", "pc held", pc_o, mdl_pc);

    repeat (2) @(negedge clk);
    check("R2", "scoreboard drained", exp_q.size(), 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule